// File: doc/BRIEF.md
# Set-Associative Cache Tag and LRU Model

This block classifies a stream of memory operations against a tag-only cache model. Each operation reports whether it was a hit, a miss into a free line, or a miss that displaced a resident block. The geometry is fixed at elaboration. There are 2^SET_BITS sets and WAYS lines per set, and each block covers 2^OFF_BITS bytes. With one way the model is direct mapped, and with zero set bits it is fully associative. No data bytes are stored. Each line holds only a valid flag, a tag and a least-recently-used rank.

Records arrive over a valid/ready handshake. Each record carries a two-bit operation code and a byte address. Instruction fetches are accepted and dropped. Loads and stores each perform one lookup. A modify record performs a load and then a store to the same address, and holds the handshake off for one cycle while it does so. Each lookup produces one registered result one cycle after it is issued. Running counters keep hits, misses, evictions and a cycle cost at one cycle per access plus one hundred per miss. Dividing the cycle cost by the access count gives the average access time, and that division is left to the user.

Top module: `cache_tag_lru`

## Requirements
- R1: The address splits into the low OFF_BITS offset bits, the next SET_BITS set-index bits and the remaining upper tag bits. A lookup hits only if a valid line in the indexed set holds an equal tag.
- R2: Any miss installs the block in the indexed set. This includes a store miss, so the store allocates. A later access to any byte of that block then hits, until the block is displaced.
- R3: On a miss the model uses a free line when the set has one. Otherwise it replaces the line whose last access is oldest.
- R4: A miss in a full set reports kind 2 (evict). A miss with a free line reports kind 1 (miss). A hit reports kind 0.
- R5: Op code 0 (instruction fetch) is accepted. It produces no result and leaves every counter unchanged.
- R6: Op code 1 is a load and op code 2 is a store, and each gives one result. Op code 3 (modify) gives a load result and, one cycle later, a store result for the same address. The store result is always a hit. `rec_ready` is low in the cycle between them.
- R7: `hit_count`, `miss_count` and `evict_count` count the results of each kind. An eviction counts as a miss as well.
- R8: `cycle_total` adds 1 for every hit and 101 for every miss.
- R9: Synchronous reset invalidates every line and clears all counters and the result output. After reset, `rec_ready` is high.
- R10: Use 16 sets, 1 way and 16-byte blocks. The sequence L 0x10, M 0x20, L 0x22, S 0x18, L 0x110, L 0x210, M 0x12 gives the kinds 1,1,0,0,0,2,2,2,0. It ends with 4 hits, 5 misses, 3 evictions and a cycle total of 509.
- R11: Each result appears one cycle after its lookup is issued. It carries the looked-up address and a store flag that is 1 for a store and for the second half of a modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record accepted when high together with rec_valid |
| rec_op | input | 2 | 0 fetch, 1 load, 2 store, 3 modify |
| rec_addr | input | ADDR_W | Byte address |
| res_valid | output | 1 | Result present |
| res_kind | output | 2 | 0 hit, 1 miss, 2 miss with eviction |
| res_is_store | output | 1 | Result belongs to a store access |
| res_addr | output | ADDR_W | Address that was looked up |
| hit_count | output | CNT_W | Hits so far |
| miss_count | output | CNT_W | Misses so far |
| evict_count | output | CNT_W | Evictions so far |
| cycle_total | output | CNT_W | Accumulated access cost in cycles |

## Verification
The bench fills a four-way set, reuses its oldest block and then forces two evictions in a row. An LRU rank that fails to age the other lines would evict the wrong block, and the next hit would show up as an evict. Instruction fetches are mixed into the stream. A model that counted them, or put out a result for them, would show changed counters or an unexpected result. Modify records are checked for their two ordered results and for the stall cycle between them. If the second half were lost, its store result would be missing. If it were issued late, the handshake would not be low in that cycle. The direct-mapped sequence checks that tags, the set index and the eviction count are taken from the right address bits.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        OP_IFETCH = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_MODIFY = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_HIT   = 2'd0,
        RES_MISS  = 2'd1,
        RES_EVICT = 2'd2
    } res_e;

    localparam int HIT_COST  = 1;
    localparam int MISS_COST = 100;

    function automatic int rank_width(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/cache_rec_seq.sv
module cache_rec_seq
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    input  logic [1:0]        rec_op,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              rec_ready,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_store,
    output logic              acc_second
);
    op_e               op_in;
    logic              take;
    logic              pend;
    logic [ADDR_W-1:0] held;

    assign op_in     = op_e'(rec_op);
    assign rec_ready = !pend;
    assign take      = rec_valid && rec_ready;

    // second half of a modify is queued here for one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            held <= '0;
        end else if (take && op_in == OP_MODIFY) begin
            pend <= 1'b1;
            held <= rec_addr;
        end else begin
            pend <= 1'b0;
        end
    end

    assign acc_valid  = pend || (take && op_in != OP_IFETCH);
    assign acc_addr   = pend ? held : rec_addr;
    assign acc_store  = pend || (op_in == OP_STORE);
    assign acc_second = pend;

    // R6
    modify_split_chk: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && rec_op == 2'd3) |=>
            (!rec_ready && acc_valid && acc_store && acc_addr == $past(rec_addr)));

endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store
    import cache_tag_pkg::*;
#(
    parameter int SET_BITS = 2,
    parameter int WAYS     = 4,
    parameter int OFF_BITS = 4,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              look_hit,
    output logic              look_evict
);
    localparam int SETS  = 1 << SET_BITS;
    localparam int IDX_W = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int TAG_W = ADDR_W - SET_BITS - OFF_BITS;
    localparam int AGE_W = rank_width(WAYS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [AGE_W-1:0] age;
    } line_t;

    line_t            lines [SETS][WAYS];
    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way, free_way, old_way, touch_way;
    logic [AGE_W-1:0] old_age, ref_age;
    logic             have_free;
    logic             unused_offset;

    assign unused_offset = ^acc_addr[OFF_BITS-1:0];
    assign tag_in        = acc_addr[ADDR_W-1 -: TAG_W];

    generate
        if (SET_BITS > 0) begin : g_indexed
            assign set_idx = acc_addr[OFF_BITS +: IDX_W];
        end else begin : g_single
            assign set_idx = '0;
        end
    endgenerate

    always_comb begin
        hit_vec   = '0;
        hit_way   = '0;
        free_way  = '0;
        have_free = 1'b0;
        old_way   = '0;
        old_age   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lines[set_idx][w].valid && lines[set_idx][w].tag == tag_in) begin
                hit_vec[w] = 1'b1;
                hit_way    = WAY_W'(w);
            end
            if (!lines[set_idx][w].valid && !have_free) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
            if (lines[set_idx][w].valid && lines[set_idx][w].age >= old_age) begin
                old_age = lines[set_idx][w].age;
                old_way = WAY_W'(w);
            end
        end
    end

    assign look_hit   = |hit_vec;
    assign look_evict = !look_hit && !have_free;
    assign touch_way  = look_hit ? hit_way : (have_free ? free_way : old_way);
    // lines ranked below this one move one step older
    assign ref_age    = look_hit ? lines[set_idx][hit_way].age
                      : (have_free ? '1 : old_age);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
        end else if (acc_valid) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    lines[set_idx][w].valid <= 1'b1;
                    lines[set_idx][w].tag   <= tag_in;
                    lines[set_idx][w].age   <= '0;
                end else if (lines[set_idx][w].valid &&
                             lines[set_idx][w].age < ref_age) begin
                    lines[set_idx][w].age <= lines[set_idx][w].age + 1'b1;
                end
            end
        end
    end

    // R1
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $onehot0(hit_vec));

endmodule

// File: rtl/cache_stats.sv
module cache_stats
    import cache_tag_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [1:0]       res_kind,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] evict_count,
    output logic [CNT_W-1:0] cycle_total
);
    localparam logic [CNT_W-1:0] HIT_INC  = CNT_W'(HIT_COST);
    localparam logic [CNT_W-1:0] MISS_INC = CNT_W'(HIT_COST + MISS_COST);

    res_e kind;
    assign kind = res_e'(res_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count   <= '0;
            miss_count  <= '0;
            evict_count <= '0;
            cycle_total <= '0;
        end else if (res_valid) begin
            if (kind == RES_HIT) begin
                hit_count   <= hit_count + 1'b1;
                cycle_total <= cycle_total + HIT_INC;
            end else begin
                miss_count  <= miss_count + 1'b1;
                cycle_total <= cycle_total + MISS_INC;
                if (kind == RES_EVICT) evict_count <= evict_count + 1'b1;
            end
        end
    end

    // R7
    hit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd0) |=> hit_count == $past(hit_count) + 1'b1);

    // R8
    cost_step_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> cycle_total ==
            $past(cycle_total) + (($past(res_kind) == 2'd0) ? HIT_INC : MISS_INC));

    // R7
    evict_bound_chk: assert property (@(posedge clk) disable iff (rst)
        evict_count <= miss_count);

endmodule

// File: rtl/cache_tag_lru.sv
module cache_tag_lru
    import cache_tag_pkg::*;
#(
    parameter int SET_BITS = 2,
    parameter int WAYS     = 4,
    parameter int OFF_BITS = 4,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [1:0]        rec_op,
    input  logic [ADDR_W-1:0] rec_addr,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic              res_is_store,
    output logic [ADDR_W-1:0] res_addr,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  evict_count,
    output logic [CNT_W-1:0]  cycle_total
);
    logic              acc_valid, acc_store, acc_second;
    logic [ADDR_W-1:0] acc_addr;
    logic              look_hit, look_evict;
    res_e              kind_next;

    cache_rec_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst),
        .rec_valid(rec_valid), .rec_op(rec_op), .rec_addr(rec_addr),
        .rec_ready(rec_ready),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_store(acc_store), .acc_second(acc_second)
    );

    cache_tag_store #(
        .SET_BITS(SET_BITS), .WAYS(WAYS), .OFF_BITS(OFF_BITS), .ADDR_W(ADDR_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .look_hit(look_hit), .look_evict(look_evict)
    );

    assign kind_next = look_hit ? RES_HIT : (look_evict ? RES_EVICT : RES_MISS);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid    <= 1'b0;
            res_kind     <= 2'd0;
            res_is_store <= 1'b0;
            res_addr     <= '0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_kind     <= kind_next;
                res_is_store <= acc_store;
                res_addr     <= acc_addr;
            end
        end
    end

    cache_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst),
        .res_valid(res_valid), .res_kind(res_kind),
        .hit_count(hit_count), .miss_count(miss_count),
        .evict_count(evict_count), .cycle_total(cycle_total)
    );

    // R6
    modify_tail_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_second) |=> (res_valid && res_kind == 2'd0 && res_is_store));

endmodule

// File: tb/cache_tag_lru_test.sv
`timescale 1ns/1ps
module cache_tag_lru_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        rec_valid, rec_ready, res_valid, res_is_store;
    logic [1:0]  rec_op, res_kind;
    logic [31:0] rec_addr, res_addr;
    logic [31:0] hit_count, miss_count, evict_count, cycle_total;

    logic        d_valid, d_ready, d_res_valid, d_res_store;
    logic [1:0]  d_op, d_res_kind;
    logic [31:0] d_addr, d_res_addr, d_hits, d_misses, d_evicts, d_cycles;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cache_tag_lru #(.SET_BITS(2), .WAYS(4), .OFF_BITS(4)) uut (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_op(rec_op), .rec_addr(rec_addr), .res_valid(res_valid),
        .res_kind(res_kind), .res_is_store(res_is_store), .res_addr(res_addr),
        .hit_count(hit_count), .miss_count(miss_count),
        .evict_count(evict_count), .cycle_total(cycle_total)
    );

    cache_tag_lru #(.SET_BITS(4), .WAYS(1), .OFF_BITS(4)) uut_dm (
        .clk(clk), .rst(rst), .rec_valid(d_valid), .rec_ready(d_ready),
        .rec_op(d_op), .rec_addr(d_addr), .res_valid(d_res_valid),
        .res_kind(d_res_kind), .res_is_store(d_res_store), .res_addr(d_res_addr),
        .hit_count(d_hits), .miss_count(d_misses),
        .evict_count(d_evicts), .cycle_total(d_cycles)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model: 4 sets x 4 ways, 16-byte blocks, LRU by timestamp
    bit  mv [4][4];
    int  mt [4][4];
    int  ms [4][4];
    int  stamp = 0;
    int  m_hits = 0, m_miss = 0, m_evict = 0;

    function automatic void model_clear();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                mv[s][w] = 0; mt[s][w] = 0; ms[s][w] = 0;
            end
        m_hits = 0; m_miss = 0; m_evict = 0;
    endfunction

    function automatic logic [1:0] model(input logic [31:0] a);
        int s = int'((a >> 4) & 32'd3);
        int t = int'(a >> 6);
        int v = 0;
        int oldest;
        bit done = 0;
        stamp++;
        for (int w = 0; w < 4; w++)
            if (!done && mv[s][w] && mt[s][w] == t) begin
                ms[s][w] = stamp; done = 1;
            end
        if (done) begin m_hits++; return 2'd0; end
        m_miss++;
        for (int w = 0; w < 4; w++)
            if (!done && !mv[s][w]) begin
                mv[s][w] = 1; mt[s][w] = t; ms[s][w] = stamp; done = 1;
            end
        if (done) return 2'd1;
        oldest = ms[s][0];
        for (int w = 1; w < 4; w++)
            if (ms[s][w] < oldest) begin oldest = ms[s][w]; v = w; end
        mt[s][v] = t; ms[s][v] = stamp;
        m_evict++;
        return 2'd2;
    endfunction

    // scoreboard queues
    logic [1:0]  q_kind [$];
    logic        q_st   [$];
    logic [31:0] q_addr [$];
    string       q_req  [$];

    function automatic void push(input logic [1:0] k, input logic st,
                                 input logic [31:0] a, input string req);
        q_kind.push_back(k); q_st.push_back(st);
        q_addr.push_back(a); q_req.push_back(req);
    endfunction

    task automatic send(input logic [1:0] op, input logic [31:0] a, input string req);
        rec_valid = 1'b1; rec_op = op; rec_addr = a;
        while (!rec_ready) @(negedge clk);
        case (op)
            2'd1: push(model(a), 1'b0, a, req);
            2'd2: push(model(a), 1'b1, a, req);
            2'd3: begin
                push(model(a), 1'b0, a, req);
                push(model(a), 1'b1, a, "R6");
            end
            default: ;
        endcase
        @(negedge clk);
        rec_valid = 1'b0;
        if (op == 2'd3) chk("R6", "ready during modify tail", rec_ready, 0);
    endtask

    // monitor for the main instance
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q_kind.size() == 0) begin
                chk("R5", "unexpected result", 1, 0);
            end else begin
                string r = q_req.pop_front();
                chk(r, "result kind", res_kind, q_kind.pop_front());
                chk("R11", "store flag", res_is_store, q_st.pop_front());
                chk("R11", "result addr", res_addr, q_addr.pop_front());
            end
        end
    end

    // capture for the direct-mapped instance
    logic [1:0] dm_kinds [16];
    logic       dm_st    [16];
    int         dm_n = 0;
    always @(negedge clk) begin
        if (!rst && d_res_valid && dm_n < 16) begin
            dm_kinds[dm_n] = d_res_kind;
            dm_st[dm_n]    = d_res_store;
            dm_n++;
        end
    end

    task automatic send_dm(input logic [1:0] op, input logic [31:0] a);
        d_valid = 1'b1; d_op = op; d_addr = a;
        while (!d_ready) @(negedge clk);
        @(negedge clk);
        d_valid = 1'b0;
    endtask

    function automatic logic [31:0] adr(input int tag, input int set, input int off);
        return 32'((tag << 6) | (set << 4) | off);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] h0, m0, c0;
        logic [1:0]  dm_exp_k [9] = '{2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd0};
        logic        dm_exp_s [9] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
        rst = 1'b1; rec_valid = 1'b0; rec_op = 2'd0; rec_addr = '0;
        d_valid = 1'b0; d_op = 2'd0; d_addr = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9", "ready after reset", rec_ready, 1);
        chk("R9", "res_valid after reset", res_valid, 0);
        chk("R9", "hits after reset", hit_count, 0);
        chk("R9", "cycles after reset", cycle_total, 0);

        // R1 R2: fill set 0, reuse same block at other offset
        for (int t = 1; t <= 4; t++) send(2'd1, adr(t, 0, 0), "R2");
        send(2'd1, adr(1, 0, 12), "R1");
        send(2'd1, adr(1, 1, 0), "R1");       // same tag, other set: miss
        // R2 R3 R4: store miss into full set evicts LRU (tag 2), allocates
        send(2'd2, adr(5, 0, 4), "R4");
        send(2'd1, adr(5, 0, 8), "R2");
        send(2'd1, adr(2, 0, 0), "R3");       // evicts tag 3
        send(2'd1, adr(1, 0, 0), "R3");
        send(2'd1, adr(4, 0, 0), "R3");
        send(2'd1, adr(3, 0, 0), "R3");

        // R5: fetches produce nothing and leave counters alone
        repeat (2) @(negedge clk);
        h0 = hit_count; m0 = miss_count; c0 = cycle_total;
        send(2'd0, adr(9, 2, 0), "R5");
        send(2'd0, adr(1, 0, 0), "R5");
        repeat (3) @(negedge clk);
        chk("R5", "hits after fetches", hit_count, h0);
        chk("R5", "misses after fetches", miss_count, m0);
        chk("R5", "cycles after fetches", cycle_total, c0);
        send(2'd1, adr(9, 2, 0), "R5");       // fetch did not install

        // R6: modify on new and on resident blocks
        send(2'd3, adr(7, 3, 0), "R6");
        send(2'd3, adr(7, 3, 2), "R6");
        send(2'd3, adr(6, 0, 0), "R6");

        // R3: mixed pattern over few tags in sets 1..3
        for (int i = 0; i < 60; i++) begin
            int t = (i * 7 + i / 3) % 6;
            int s = 1 + (i % 3);
            send(2'(1 + (i % 3)), adr(t, s, i % 16), "R3");
        end

        repeat (4) @(negedge clk);
        chk("R6", "queue drained", q_kind.size(), 0);
        chk("R7", "hit count", hit_count, m_hits);
        chk("R7", "miss count", miss_count, m_miss);
        chk("R7", "evict count", evict_count, m_evict);
        chk("R8", "cycle total", cycle_total, m_hits + 101 * m_miss);

        // R9: reset mid-run clears state and counters
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R9", "hits after second reset", hit_count, 0);
        chk("R9", "evicts after second reset", evict_count, 0);
        send(2'd1, adr(1, 0, 0), "R9");       // was resident: must miss
        repeat (3) @(negedge clk);

        // R10: direct-mapped worked sequence
        send_dm(2'd1, 32'h10);
        send_dm(2'd3, 32'h20);
        send_dm(2'd1, 32'h22);
        send_dm(2'd2, 32'h18);
        send_dm(2'd1, 32'h110);
        send_dm(2'd1, 32'h210);
        send_dm(2'd3, 32'h12);
        repeat (4) @(negedge clk);
        chk("R10", "dm result count", dm_n, 9);
        for (int i = 0; i < 9; i++) begin
            chk("R10", $sformatf("dm kind %0d", i), dm_kinds[i], dm_exp_k[i]);
            chk("R11", $sformatf("dm store flag %0d", i), dm_st[i], dm_exp_s[i]);
        end
        chk("R10", "dm hits", d_hits, 4);
        chk("R10", "dm misses", d_misses, 5);
        chk("R10", "dm evictions", d_evicts, 3);
        chk("R10", "dm cycles", d_cycles, 509);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule